// File: doc/BRIEF.md
# Glitchless Output-Enable Gating Matrix

This block sits between a set of free-running source clocks and the output pads of a clock generator. Each output is turned on or off by a small group of active-low enable pins. A configuration mask says which pins control which outputs. An output turns on only at the start of a clock cycle and turns off only after its current high phase has ended, so the pad never shows a shortened pulse.

While an output is off, it rests in an idle state chosen by a per-output code. The idle state is a driven low, a driven high, or a released (high-impedance) pad. An active-high power-down input forces every output to release its pad at once and clears all enable state. After power-down ends, each output must go through the normal turn-on sequence again.

The enable request for each output is resynchronised into that output's own clock domain. Every lane therefore switches on its own clock edges, independent of the other lanes and of the pin timing.

Top module: `oe_gate_matrix`

## Requirements
- R1: Bit `p*N_OUT+i` of `link_mask` links enable pin p to output i. An output is requested on when none of its linked pins is high. An output with no linked pin is always requested on.
- R2: When an output is linked to several pins, one pin held high keeps it off even when every other linked pin is low.
- R3: A change in an output's request is captured by two rising edges of that output's source clock. The output's gate takes the new value at the following falling edge. On turn-on, the first thing the pad shows is therefore a complete high phase, which begins at the next rising edge.
- R4: On turn-off, the gate closes only at a falling edge, after the current high phase has completed. Once the request has been off at two successive rising edges, the gate is closed at the next rising edge.
- R5: While the idle code is 00, every high pulse on `clk_out[i]` lasts exactly one full high phase of `src_clk[i]`.
- R6: While output i is off, `idle_mode[2i+1:2i]` selects its pad state. 00 gives `clk_out`=0 with `drv_en`=1. 01 gives `clk_out`=1 with `drv_en`=1. 10 and 11 give `clk_out`=0 with `drv_en`=0 (high impedance). The code can be changed while the output is off and takes effect immediately. While the output is on, it drives its source clock with `drv_en`=1, whatever its idle code.
- R7: While `pdn` is 1, every output shows `clk_out`=0 and `drv_en`=0, without waiting for any clock edge.
- R8: After `pdn` returns to 0, an output whose request is on restarts through the full R3 sequence. No enable state survives power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | N_OUT | Free-running source clock for each output |
| oe_n | input | N_PIN | Active-low enable pins; 1 requests disable |
| pdn | input | 1 | Power-down, active high; also clears all state asynchronously |
| link_mask | input | N_PIN*N_OUT | Pin-to-output links, bit p*N_OUT+i |
| idle_mode | input | 2*N_OUT | Per-output idle code, two bits per output |
| clk_out | output | N_OUT | Gated clock value for each pad |
| drv_en | output | N_OUT | Pad drive enable; 0 means high impedance |

## Verification
A bad gate or synchroniser bit in a lane shows up at that lane's pads. The lane either toggles while it should be idle or rests at its idle level while it should toggle. This is visible at the first source-clock half period after the fault, because the gate is applied combinationally to the source clock. A gate that updates on the wrong edge shows up as a high pulse longer or shorter than the source high phase, at the first turn-on or turn-off. A wrong synchroniser depth shifts the switching point by one whole source period, which a per-cycle model comparison detects within that period. A wrong pin-mask decode or a lost power-down clear shows up as lanes that switch on patterns of `oe_n` that should not affect them.

// File: rtl/oe_gate_pkg.sv
package oe_gate_pkg;

  typedef enum logic [1:0] {
    IDLE_LOW   = 2'b00,
    IDLE_HIGH  = 2'b01,
    IDLE_FLOAT = 2'b10,
    IDLE_SPARE = 2'b11
  } idle_code_e;

  typedef struct packed {
    logic val;
    logic drv;
  } pad_t;

  // Pad state of a lane that is switched off.
  function automatic pad_t idle_pad(input logic [1:0] code);
    pad_t p;
    case (idle_code_e'(code))
      IDLE_LOW:  p = '{val: 1'b0, drv: 1'b1};
      IDLE_HIGH: p = '{val: 1'b1, drv: 1'b1};
      default:   p = '{val: 1'b0, drv: 1'b0};
    endcase
    return p;
  endfunction

  // Full pad view: power-down wins, then gate, then idle code.
  function automatic pad_t lane_pad(input logic off, input logic gate,
                                    input logic src, input logic [1:0] code);
    pad_t p;
    if (off)       p = '{val: 1'b0, drv: 1'b0};
    else if (gate) p = '{val: src,  drv: 1'b1};
    else           p = idle_pad(code);
    return p;
  endfunction

endpackage

// File: rtl/oe_sync.sv
module oe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/oe_pin_matrix.sv
module oe_pin_matrix #(
  parameter int N_OUT = 8,
  parameter int N_PIN = 3
) (
  input  logic [N_PIN-1:0]       oe_n,
  input  logic [N_PIN*N_OUT-1:0] link_mask,
  output logic [N_OUT-1:0]       lane_req
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    logic [N_PIN-1:0] col;
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      assign col[p] = link_mask[p*N_OUT + i];
    end
    // Any linked pin that is high vetoes the lane (disable dominates).
    assign lane_req[i] = ~|(col & oe_n);
  end
endmodule

// File: rtl/oe_lane_gate.sv
module oe_lane_gate
  import oe_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       src_clk,
  input  logic       pdn,
  input  logic       req,
  input  logic [1:0] idle_code,
  output logic       gate_on,
  output logic       pad_val,
  output logic       pad_drv
);
  logic req_sync;
  pad_t pad;

  oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (src_clk),
    .clr (pdn),
    .d   (req),
    .q   (req_sync)
  );

  // Gate moves only while the source clock is low.
  always_ff @(negedge src_clk or posedge pdn) begin
    if (pdn) gate_on <= 1'b0;
    else     gate_on <= req_sync;
  end

  assign pad     = lane_pad(pdn, gate_on, src_clk, idle_code);
  assign pad_val = pad.val;
  assign pad_drv = pad.drv;
endmodule

// File: rtl/oe_gate_matrix.sv
module oe_gate_matrix #(
  parameter int N_OUT = 8,
  parameter int N_PIN = 3,
  localparam int MASK_W = N_PIN * N_OUT,
  localparam int CODE_W = 2 * N_OUT
) (
  input  logic [N_OUT-1:0]  src_clk,
  input  logic [N_PIN-1:0]  oe_n,
  input  logic              pdn,
  input  logic [MASK_W-1:0] link_mask,
  input  logic [CODE_W-1:0] idle_mode,
  output logic [N_OUT-1:0]  clk_out,
  output logic [N_OUT-1:0]  drv_en
);
  logic [N_OUT-1:0] lane_req_w;
  logic [N_OUT-1:0] gate_on_w;

  oe_pin_matrix #(.N_OUT(N_OUT), .N_PIN(N_PIN)) u_matrix (
    .oe_n      (oe_n),
    .link_mask (link_mask),
    .lane_req  (lane_req_w)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    oe_lane_gate #(.SYNC_STAGES(2)) u_lane (
      .src_clk   (src_clk[i]),
      .pdn       (pdn),
      .req       (lane_req_w[i]),
      .idle_code (idle_mode[2*i +: 2]),
      .gate_on   (gate_on_w[i]),
      .pad_val   (clk_out[i]),
      .pad_drv   (drv_en[i])
    );
  end
endmodule

// File: rtl/oe_gate_matrix_chk.sv
module oe_gate_matrix_chk #(
  parameter int N_OUT = 8
) (
  input logic [N_OUT-1:0]   src_clk,
  input logic               pdn,
  input logic [N_OUT-1:0]   clk_out,
  input logic [N_OUT-1:0]   drv_en,
  input logic [2*N_OUT-1:0] idle_mode,
  input logic [N_OUT-1:0]   lane_req,
  input logic [N_OUT-1:0]   gate_on
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    // R5
    full_high_chk: assert property (@(negedge src_clk[i]) disable iff (pdn)
      gate_on[i] |-> (clk_out[i] && drv_en[i]));

    // R6
    idle_level_chk: assert property (@(negedge src_clk[i]) disable iff (pdn)
      !gate_on[i] |-> (clk_out[i] == (idle_mode[2*i +: 2] == 2'b01))
                   && (drv_en[i] == !idle_mode[2*i+1]));

    // R4
    off_settled_chk: assert property (@(posedge src_clk[i]) disable iff (pdn)
      (($past(lane_req[i]) == 1'b0) && ($past(lane_req[i], 2) == 1'b0)) |-> !gate_on[i]);

    // R7
    always @(negedge src_clk[i]) begin
      if (pdn) begin
        pdn_quiet_chk: assert (!drv_en[i] && !clk_out[i]);
      end
    end
  end
endmodule

bind oe_gate_matrix oe_gate_matrix_chk #(.N_OUT(N_OUT)) u_chk (
  .src_clk   (src_clk),
  .pdn       (pdn),
  .clk_out   (clk_out),
  .drv_en    (drv_en),
  .idle_mode (idle_mode),
  .lane_req  (lane_req_w),
  .gate_on   (gate_on_w)
);

// File: tb/oe_gate_matrix_bench.sv
module oe_gate_matrix_bench;
  localparam int N = 8;
  localparam int P = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]   src = '0;
  int             hcnt[N] = '{default: 0};
  logic [P-1:0]   oe_n;
  logic           pdn;
  logic [P*N-1:0] mask;
  logic [2*N-1:0] idle;
  logic [N-1:0]   clk_out, drv_en;

  int    total = 0, bad = 0;
  string phase = "R7";
  bit    done = 0;

  oe_gate_matrix #(.N_OUT(N), .N_PIN(P)) u_oe_gate_matrix (
    .src_clk(src), .oe_n(oe_n), .pdn(pdn), .link_mask(mask),
    .idle_mode(idle), .clk_out(clk_out), .drv_en(drv_en)
  );

  // Source clock i: high and low phases of i+1 bench cycles each.
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (hcnt[i] == i) begin hcnt[i] <= 0; src[i] <= ~src[i]; end
      else hcnt[i] <= hcnt[i] + 1;
    end
  end

  task automatic check(string tag, int i, logic av, logic ad, logic ev, logic ed);
    total++;
    if (av !== ev || ad !== ed) begin
      bad++;
      $display("FAIL %s out%0d: clk_out=%b drv_en=%b expected clk_out=%b drv_en=%b",
               tag, i, av, ad, ev, ed);
    end
  endtask

  // Behavioural reference: request, two captures, gate on clock-low.
  bit m1[N], m2[N], mg[N], prev[N];
  int run[N];

  always @(posedge clk) begin
    #2;
    for (int i = 0; i < N; i++) begin
      bit rq, ev, ed;
      rq = 1'b1;
      for (int p = 0; p < P; p++) if (mask[p*N+i] && oe_n[p]) rq = 1'b0;
      if (pdn) begin
        m1[i] = 0; m2[i] = 0; mg[i] = 0;
      end else begin
        if (src[i] && !prev[i]) begin m2[i] = m1[i]; m1[i] = rq; end
        if (!src[i] && prev[i]) mg[i] = m2[i];
      end
      prev[i] = src[i];
      if (pdn)         begin ev = 0;      ed = 0; end
      else if (mg[i])  begin ev = src[i]; ed = 1; end
      else case (idle[2*i +: 2])
        2'b00:   begin ev = 0; ed = 1; end
        2'b01:   begin ev = 1; ed = 1; end
        default: begin ev = 0; ed = 0; end
      endcase
      check(phase, i, clk_out[i], drv_en[i], ev, ed);
      // R5: high pulse width equals the source high phase (i+1 samples)
      if (pdn || idle[2*i +: 2] != 2'b00) run[i] = 0;
      else if (clk_out[i]) run[i]++;
      else begin
        if (run[i] > 0) begin
          total++;
          if (run[i] != i + 1) begin
            bad++;
            $display("FAIL R5 out%0d: pulse width=%0d expected %0d", i, run[i], i + 1);
          end
        end
        run[i] = 0;
      end
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    pdn  = 1'b1;
    oe_n = 3'b111;
    // pin0 -> 0,2,5,7 ; pin1 -> 1,5 ; pin2 -> 3,4 ; output 6 unlinked
    mask = {8'b0001_1000, 8'b0010_0010, 8'b1010_0101};
    idle = {2'b10, 2'b00, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00};
    wait_cycles(10);
    // R7 reset state at the ports
    for (int i = 0; i < N; i++) check("R7", i, clk_out[i], drv_en[i], 1'b0, 1'b0);

    phase = "R1"; pdn = 1'b0;   wait_cycles(40);
    phase = "R3"; oe_n = 3'b000; wait_cycles(40);
    phase = "R2"; oe_n = 3'b010; wait_cycles(40);
    phase = "R4"; oe_n = 3'b110; wait_cycles(40);
    // R6: retune idle codes of lanes 1,3,5 while they are off
    phase = "R6";
    idle[3:2] = 2'b00; idle[7:6] = 2'b01; idle[11:10] = 2'b10;
    wait_cycles(20);
    phase = "R5";
    for (int k = 0; k < 30; k++) begin
      oe_n = 3'(k * 5 + 3);
      wait_cycles(3 + (k % 7) * 2);
    end
    phase = "R7"; pdn = 1'b1; oe_n = 3'b000;
    wait_cycles(3);
    for (int i = 0; i < N; i++) check("R7", i, clk_out[i], drv_en[i], 1'b0, 1'b0);
    wait_cycles(7);
    phase = "R8"; pdn = 1'b0;
    wait_cycles(40);
    finish_run();
  end
endmodule